// File: doc/BRIEF.md
# Register-Driven Serial NOR Command Sequencer

This block issues one command at a time to a serial NOR flash on behalf of software. Software fills a small word-addressed register file with an opcode, an address, a dummy-byte count, a byte count and the device to talk to. It then writes a set of phase-enable flags together with a start bit. The sequencer asserts the chosen chip select, waits a programmable setup time and shifts the enabled phases out on one data line. Phases always run in the order command, address, dummy, data. After a programmable hold time it releases the chip select, waits a programmable deselect time and sets a done flag that drives the interrupt line.

Data for the data phase lives in a 64-byte buffer window at bus offset 0x100. Bytes from a read command land there starting at byte 0. A write command drains the same bytes starting at byte 0. Register offsets are 0x00 configuration, 0x04 timing, 0x08 status, 0x0C status clear, 0x10 opcode, 0x14 address, 0x18 device select, 0x1C byte count and 0x20 operation. The bus is a single-cycle write strobe with a combinational read path. The serial clock is the core clock divided by twice `CLK_DIV`. All timing counts are in core clock cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset both chip selects are high, serial clock, MOSI and irq are low, the operation register (0x20) reads 0 and the timing register (0x04) reads 0x66F.
- R2: Enabled phases go out in the order command, address, dummy, data. Every byte is sent most significant bit first in SPI mode 0: the clock idles low, MOSI is steady while the clock is high, and MISO is sampled on the rising edge. The operation register enables the phases with bit 7 for command, bit 6 for address, bit 8 for dummy, bit 5 for write data, bit 2 for read data and bit 1 for status read. If no phase is enabled, the chip select still pulses but no clock is sent.
- R3: The address phase sends 3 bytes (register 0x14 bits 23:0) when configuration bit 10 is 0, and 4 bytes (bits 31:0) when it is 1, high byte first.
- R4: The dummy phase sends as many zero bytes as device-select register bits 3:0 give. A count of zero sends no dummy bytes even when the phase is enabled.
- R5: The byte count is register 0x1C bits 13:0. A count of zero skips the data phase for read or write and leaves the buffer unchanged.
- R6: In the buffer window, buffer byte n sits at word offset 0x100+4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). Read data byte j is stored at buffer byte j. Write data byte j is taken from buffer byte j.
- R7: A status read moves exactly one byte into buffer byte 0 whatever the count says. When write data is enabled it takes precedence over both read flags.
- R8: Device-select bit 11 picks the device: 0 drives chip select bit 0 low and 1 drives chip select bit 1 low. The other chip select stays high.
- R9: With setup field S (timing bits 7:4), the chip select is low for S+CLK_DIV+1 cycles before the first rising clock edge.
- R10: With hold field H (timing bits 11:8), the chip select stays low for H+1 cycles after the last falling clock edge.
- R11: With deselect field D (timing bits 3:0), the status done bit (0x08 bit 0) and irq rise D+1 cycles after the chip select goes high.
- R12: Writing 1 to bit 0 of the clear register (0x0C) clears the done bit. Writing 0 leaves it set.
- R13: The start bit (0x20 bit 0) clears itself. While a command runs, bit 0 reads 1 and the phase flags read back as started. Writes to 0x20 during a command neither change the flags nor start a second command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_we | input | 1 | register or window write strobe |
| bus_addr | input | ADDR_W | byte address of the register or window word |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr |
| irq | output | 1 | command done flag |
| spi_cs_n | output | 2 | active-low chip selects, one per device |
| spi_sclk | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data to flash |
| spi_miso | input | 1 | serial data from flash |

## Verification
The sequencer is run through a table of commands. These include an opcode alone and a status read, reads with 3-byte and 4-byte addresses, a read with a dummy byte, a program with buffered write data, and a read with a zero count. The table also has a command that enables both write and read, and one that enables dummy with a zero dummy count. The table separates phase ordering, address width, dummy handling, data-count skipping and write precedence, because each of these changes the byte count seen on MOSI and the buffer contents that read back. The flash model returns a byte pattern indexed by position, so any misaligned capture shows up as wrong bytes. Directed runs then vary the three timing fields, including all zeros, and separate off-by-one errors in setup, hold and deselect. They also cover the clear register, busy-time writes and a start with no phases.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W    = 9,
  parameter int BUF_BYTES = 64,
  parameter int CLK_DIV   = 2,
  parameter int CNT_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [1:0]        spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int BI_W = $clog2(BUF_BYTES);
  localparam int DC_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DC_W-1:0] DC_LAST = DC_W'(CLK_DIV - 1);

  localparam logic [2:0] PH_CMD = 3'd0, PH_ADR = 3'd1, PH_DUM = 3'd2, PH_DAT = 3'd3, PH_END = 3'd4;
  localparam logic [3:0] A_CFG = 4'd0, A_TIM = 4'd1, A_STAT = 4'd2, A_CLR = 4'd3, A_CMD = 4'd4,
                         A_ADR = 4'd5, A_SEL = 4'd6, A_CNT = 4'd7, A_OP = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_DESEL} st_t;

  st_t              st;
  logic             addr4_q, done_q, csel_q, cur_cs, cs_act, sclk_q;
  logic [11:0]      tim_q;
  logic [7:0]       opc_q;
  logic [31:0]      adr_q;
  logic [3:0]       dnum_q, tcnt;
  logic [CNT_W-1:0] cnt_q, bcnt;
  logic [8:0]       op_q;
  logic [2:0]       ph, bit_q;
  logic [DC_W-1:0]  dc;
  logic [6:0]       rx;
  logic [7:0]       dbuf [BUF_BYTES];

  wire       aligned = (bus_addr[1:0] == 2'b00);
  wire       in_win  = aligned && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:BI_W] == '0);
  wire       in_reg  = aligned && !bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:6] == '0);
  wire [3:0] ridx    = bus_addr[5:2];
  wire       reg_we  = bus_we && in_reg;
  wire       wr_op   = reg_we && (ridx == A_OP);
  wire       busy    = (st != S_IDLE);
  wire       go      = wr_op && bus_wdata[0] && !busy;
  wire       half    = (dc == DC_LAST);

  function automatic logic [3:0] has_of(input logic [8:0] f, input logic [3:0] dn,
                                        input logic [CNT_W-1:0] n);
    has_of = {(f[5] | f[2] | f[1]) && ((!f[5] && f[1]) || (n != '0)),
              f[8] && (dn != 4'd0), f[6], f[7]};
  endfunction

  function automatic logic [2:0] pick(input logic [3:0] h, input logic [2:0] from);
    pick = PH_END;
    for (int i = 3; i >= 0; i--)
      if (h[i] && (3'(i) >= from)) pick = 3'(i);
  endfunction

  logic [CNT_W-1:0] dlen, plen;
  logic [31:0]      adr_sh;
  logic [7:0]       tx_byte;
  logic [2:0]       ph_nxt;

  always_comb begin
    dlen   = (!op_q[5] && op_q[1]) ? CNT_W'(1) : cnt_q;
    adr_sh = addr4_q ? adr_q : {adr_q[23:0], 8'h00};
    ph_nxt = pick(has_of(op_q, dnum_q, cnt_q), ph + 3'd1);
    case (ph)
      PH_CMD:  begin plen = CNT_W'(1);                  tx_byte = opc_q; end
      PH_ADR:  begin plen = addr4_q ? CNT_W'(4) : CNT_W'(3);
                     tx_byte = adr_sh[{~bcnt[1:0], 3'b000} +: 8]; end
      PH_DUM:  begin plen = CNT_W'(dnum_q);             tx_byte = 8'h00; end
      default: begin plen = dlen;
                     tx_byte = op_q[5] ? dbuf[bcnt[BI_W-1:0]] : 8'h00; end
    endcase
  end

  wire last_byte = (bcnt == plen - CNT_W'(1));
  wire cap_we    = (st == S_SHIFT) && half && !sclk_q && (bit_q == 3'd7) &&
                   (ph == PH_DAT) && !op_q[5];

  always_ff @(posedge clk) begin
    if (bus_we && in_win)
      for (int b = 0; b < 4; b++)
        dbuf[{bus_addr[BI_W-1:2], 2'(b)}] <= bus_wdata[8*b +: 8];
    if (cap_we)
      dbuf[bcnt[BI_W-1:0]] <= {rx, spi_miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  addr4_q <= 1'b0; done_q <= 1'b0; csel_q <= 1'b0; cur_cs <= 1'b0;
      cs_act <= 1'b0; sclk_q <= 1'b0; tim_q <= 12'h66F; opc_q <= '0; adr_q <= '0;
      dnum_q <= '0; tcnt <= '0; cnt_q <= '0; bcnt <= '0; op_q <= '0; ph <= PH_END;
      bit_q <= '0; dc <= '0; rx <= '0;
    end else begin
      if (reg_we) begin
        case (ridx)
          A_CFG: addr4_q <= bus_wdata[10];
          A_TIM: tim_q   <= bus_wdata[11:0];
          A_CMD: opc_q   <= bus_wdata[7:0];
          A_ADR: adr_q   <= bus_wdata;
          A_SEL: begin csel_q <= bus_wdata[11]; dnum_q <= bus_wdata[3:0]; end
          A_CNT: cnt_q   <= bus_wdata[CNT_W-1:0];
          A_OP:  if (!busy) op_q <= {bus_wdata[8:1], 1'b0};
          A_CLR: if (bus_wdata[0]) done_q <= 1'b0;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          st <= S_SETUP; cs_act <= 1'b1; cur_cs <= csel_q; tcnt <= tim_q[7:4];
          ph <= pick(has_of(bus_wdata[8:0], dnum_q, cnt_q), PH_CMD);
          bcnt <= '0; bit_q <= '0; dc <= '0;
        end
        S_SETUP:
          if (tcnt != 4'd0) tcnt <= tcnt - 4'd1;
          else if (ph == PH_END) begin st <= S_HOLD; tcnt <= tim_q[11:8]; end
          else st <= S_SHIFT;
        S_SHIFT:
          if (!half) dc <= dc + DC_W'(1);
          else begin
            dc <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) rx <= {rx[5:0], spi_miso};
            else if (bit_q != 3'd7) bit_q <= bit_q + 3'd1;
            else begin
              bit_q <= '0;
              if (last_byte) begin
                bcnt <= '0;
                ph <= ph_nxt;
                if (ph_nxt == PH_END) begin st <= S_HOLD; tcnt <= tim_q[11:8]; end
              end else bcnt <= bcnt + CNT_W'(1);
            end
          end
        S_HOLD:
          if (tcnt != 4'd0) tcnt <= tcnt - 4'd1;
          else begin cs_act <= 1'b0; st <= S_DESEL; tcnt <= tim_q[3:0]; end
        S_DESEL:
          if (tcnt != 4'd0) tcnt <= tcnt - 4'd1;
          else begin st <= S_IDLE; done_q <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign irq      = done_q;
  assign spi_sclk = sclk_q;
  assign spi_cs_n = !cs_act ? 2'b11 : (cur_cs ? 2'b01 : 2'b10);
  assign spi_mosi = (st == S_SHIFT) ? tx_byte[~bit_q] : 1'b0;

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      for (int b = 0; b < 4; b++)
        bus_rdata[8*b +: 8] = dbuf[{bus_addr[BI_W-1:2], 2'(b)}];
    end else if (in_reg) begin
      case (ridx)
        A_CFG:  bus_rdata[10]      = addr4_q;
        A_TIM:  bus_rdata[11:0]    = tim_q;
        A_STAT: bus_rdata[0]       = done_q;
        A_CMD:  bus_rdata[7:0]     = opc_q;
        A_ADR:  bus_rdata          = adr_q;
        A_SEL:  begin bus_rdata[11] = csel_q; bus_rdata[3:0] = dnum_q; end
        A_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
        A_OP:   bus_rdata[8:0]     = {op_q[8:1], busy};
        default: ;
      endcase
    end
  end

  assert_cs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);
  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  assert_cs_edge_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> !spi_sclk);
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_op) |=> (op_q == $past(op_q)));
  assert_done_after_desel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st) == S_DESEL));
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
  localparam int HALF = 2;
  localparam logic [8:0] R_CFG = 9'h000, R_TIM = 9'h004, R_STAT = 9'h008, R_CLR = 9'h00C,
                         R_CMD = 9'h010, R_ADR = 9'h014, R_SEL = 9'h018, R_CNT = 9'h01C,
                         R_OP = 9'h020, R_WIN = 9'h100;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, spi_miso = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sclk, spi_mosi;
  logic [1:0] spi_cs_n;

  nor_cmd_seq #(.ADDR_W(9), .BUF_BYTES(64), .CLK_DIV(HALF), .CNT_W(14)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #4 clk = ~clk;

  int total = 0, bad = 0;

  function automatic logic [7:0] resp(input int k); return 8'(k * 29 + 90); endfunction
  function automatic logic [7:0] pb(input int j);   return 8'(j * 7 + 17);  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor and flash model
  logic p_cs_lo = 1'b0, p_sclk = 1'b0, seen_rise = 1'b0, have_fall = 1'b0, desel_on = 1'b0;
  int setup_cnt = 0, hold_cnt = 0, desel_cnt = 0, nbits = 0, fbit = 0, cs_falls = 0;
  logic [1:0] cs_seen = 2'b00;
  logic [7:0] shreg = '0;
  logic [7:0] mbytes [32];
  logic cs_lo;

  always @(negedge clk) begin
    cs_lo = (spi_cs_n != 2'b11);
    if (cs_lo && !p_cs_lo) begin
      nbits = 0; setup_cnt = 0; seen_rise = 1'b0; have_fall = 1'b0; hold_cnt = 0;
      fbit = 0; cs_falls++; spi_miso = resp(0)[7];
    end
    cs_seen = cs_seen | ~spi_cs_n;
    if (cs_lo && !seen_rise) begin
      if (spi_sclk) seen_rise = 1'b1; else setup_cnt++;
    end
    if (!p_sclk && spi_sclk) begin
      shreg = {shreg[6:0], spi_mosi};
      nbits++;
      if ((nbits % 8 == 0) && (nbits / 8 <= 32)) mbytes[nbits/8 - 1] = shreg;
    end
    if (p_sclk && !spi_sclk) begin
      have_fall = 1'b1; hold_cnt = 1; fbit++;
      spi_miso = resp(fbit / 8)[7 - fbit % 8];
    end else if (cs_lo && have_fall && !spi_sclk) hold_cnt++;
    if (!cs_lo && p_cs_lo) begin desel_on = 1'b1; desel_cnt = 0; end
    if (desel_on && !cs_lo) begin
      if (irq) desel_on = 1'b0; else desel_cnt++;
    end
    p_cs_lo = cs_lo;
    p_sclk = spi_sclk;
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic start_op(input logic [8:0] fl);
    wr(R_CLR, 32'h1);
    @(posedge clk); cs_falls = 0; cs_seen = 2'b00;
    wr(R_OP, {23'h0, fl[8:1], 1'b1});
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(req, irq, 1'b1);
  endtask

  task automatic preload();
    for (int w = 0; w < 16; w++)
      wr(R_WIN + 9'(4 * w), {pb(4*w+3), pb(4*w+2), pb(4*w+1), pb(4*w)});
  endtask

  typedef struct packed {
    logic [8:0]  fl;
    logic [7:0]  opc;
    logic [31:0] adr;
    logic        a4;
    logic [3:0]  dn;
    logic [13:0] cnt;
    logic        cs;
    logic [7:0]  nb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{9'h080, 8'h06, 32'h00000000, 1'b0, 4'd0, 14'd0, 1'b0, 8'd1},   // opcode only
    '{9'h082, 8'h05, 32'h00000000, 1'b0, 4'd0, 14'd0, 1'b1, 8'd2},   // status read
    '{9'h0C4, 8'h03, 32'h00123456, 1'b0, 4'd0, 14'd5, 1'b0, 8'd9},   // 3-byte read
    '{9'h1C4, 8'h0C, 32'hA1B2C3D4, 1'b1, 4'd1, 14'd6, 1'b1, 8'd12},  // 4-byte + dummy read
    '{9'h0E0, 8'h02, 32'h000ABCDE, 1'b0, 4'd0, 14'd7, 1'b0, 8'd11},  // program
    '{9'h0C4, 8'h03, 32'h00001000, 1'b0, 4'd0, 14'd0, 1'b1, 8'd4},   // zero count read
    '{9'h0E4, 8'h02, 32'h00777777, 1'b0, 4'd0, 14'd2, 1'b0, 8'd6},   // write beats read
    '{9'h184, 8'h0B, 32'h00000000, 1'b0, 4'd0, 14'd2, 1'b1, 8'd3}    // dummy with zero count
  };

  initial begin
    vec_t t;
    logic [31:0] d, sh, act_a, exp_a;
    logic [7:0] eb;
    int na, nd, dl, npre;
    logic wrd;

    repeat (5) @(negedge clk);
    #1;
    chk("R1 cs", spi_cs_n, 2'b11);
    chk("R1 sclk", spi_sclk, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    rd(R_OP, d);  chk("R1 op", d, 32'h0);
    rd(R_TIM, d); chk("R1 timing", d, 32'h66F);
    chk("R1 mosi", spi_mosi, 1'b0);

    for (int v = 0; v < 8; v++) begin
      t = VECS[v];
      wr(R_CFG, {21'h0, t.a4, 10'h0});
      wr(R_SEL, {20'h0, t.cs, 7'h0, t.dn});
      wr(R_CMD, {24'h0, t.opc});
      wr(R_ADR, t.adr);
      wr(R_CNT, {18'h0, t.cnt});
      preload();
      start_op(t.fl);
      wait_done("R11 done");
      na  = t.fl[6] ? (t.a4 ? 4 : 3) : 0;
      nd  = t.fl[8] ? int'(t.dn) : 0;
      wrd = t.fl[5];
      dl  = wrd ? int'(t.cnt) : (t.fl[1] ? 1 : (t.fl[2] ? int'(t.cnt) : 0));
      npre = (t.fl[7] ? 1 : 0) + na + nd;
      chk("R2 bytes on wire", nbits, 8 * int'(t.nb));
      chk("R5 byte total", npre + dl, int'(t.nb));
      chk("R8 device", cs_seen, t.cs ? 2'b10 : 2'b01);
      if (t.fl[7]) chk("R2 opcode first", mbytes[0], t.opc);
      if (na > 0) begin
        sh = (na == 4) ? t.adr : (t.adr << 8);
        act_a = '0; exp_a = '0;
        for (int k = 0; k < na; k++) begin
          act_a = {act_a[23:0], mbytes[1 + k]};
          exp_a = {exp_a[23:0], sh[31 - 8*k -: 8]};
        end
        chk("R3 address", act_a, exp_a);
      end
      for (int k = 0; k < nd; k++) chk("R4 dummy zero", mbytes[1 + na + k], 8'h00);
      if (wrd) begin
        for (int j = 0; j < dl; j++) chk("R6 write data", mbytes[npre + j], pb(j));
      end else begin
        for (int w = 0; w < 2; w++) begin
          rd(R_WIN + 9'(4 * w), d);
          for (int b = 0; b < 4; b++) begin
            eb = (4*w + b < dl) ? resp(npre + 4*w + b) : pb(4*w + b);
            exp_a[8*b +: 8] = eb;
          end
          chk(t.fl[1] ? "R7 status byte" : "R6 read buffer", d, exp_a);
        end
      end
      chk("R9 setup", setup_cnt, 6 + HALF + 1);
      chk("R10 hold", hold_cnt, 6 + 1);
      chk("R11 deselect", desel_cnt, 15 + 1);
      rd(R_OP, d); chk("R13 start cleared", d, {23'h0, t.fl[8:1], 1'b0});
    end

    // timing variants: hold 3, setup 2, deselect 5; then all zero
    wr(R_TIM, 32'h325);
    wr(R_SEL, 32'h0);
    start_op(9'h080);
    wait_done("R11 done");
    chk("R9 setup 2", setup_cnt, 2 + HALF + 1);
    chk("R10 hold 3", hold_cnt, 4);
    chk("R11 deselect 5", desel_cnt, 6);
    wr(R_TIM, 32'h000);
    start_op(9'h080);
    wait_done("R11 done");
    chk("R9 setup 0", setup_cnt, HALF + 1);
    chk("R10 hold 0", hold_cnt, 1);
    chk("R11 deselect 0", desel_cnt, 1);

    // clear register
    wr(R_CLR, 32'h0);
    @(negedge clk);
    chk("R12 zero write keeps done", irq, 1'b1);
    rd(R_STAT, d); chk("R12 status bit", d, 32'h1);
    wr(R_CLR, 32'h1);
    @(negedge clk);
    chk("R12 clear", irq, 1'b0);

    // no phases enabled
    start_op(9'h000);
    wait_done("R2 empty done");
    chk("R2 empty no clock", nbits, 0);
    chk("R2 empty cs pulse", cs_falls, 1);

    // busy-time writes
    wr(R_TIM, 32'h66F);
    wr(R_CNT, 32'd4);
    start_op(9'h0C4);
    repeat (10) @(negedge clk);
    rd(R_OP, d); chk("R13 busy readback", d, 32'h0C5);
    wr(R_OP, 32'h0E1);
    rd(R_OP, d); chk("R13 busy write ignored", d, 32'h0C5);
    wait_done("R13 done");
    rd(R_OP, d); chk("R13 idle readback", d, 32'h0C4);
    repeat (60) @(negedge clk);
    chk("R13 no second start", cs_falls, 1);
    chk("R13 lines idle", spi_cs_n, 2'b11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule